// File: doc/BRIEF.md
# Prioritised Interrupt Collector

This block gathers a configurable number of level-sensitive interrupt lines and presents a single request line to a processor. Each line has its own small control word holding an enable and a priority level. A combinational arbiter picks, among lines that are both high and enabled, the one with the highest level. On a tie it picks the lowest line number. A global request-enable bit in a control word can silence the whole block.

Software reaches every writable word through four addresses inside a 16-byte slot. The address bits [3:2] select the operation: replace the word, OR in the written ones, clear the written ones, or invert the written ones. A read at any of the four addresses returns the same value. Reading the status word hands the current winner to software. That read also marks the winner's level as in service. From then on, only a line at a strictly higher level can raise the request, until software releases the level through the acknowledge word. This gives up to four nested service levels.

The bus has one read strobe and one write strobe. Read data appears on the cycle after the read strobe. Interrupt inputs pass through a parameterised number of sampling flops before arbitration.

Top module: `irq_collector`

## Requirements
- R1: After reset every line's control word is 0 (level 0, disabled), the control word at 0x020 reads 0, the acknowledge word at 0x010 reads 0, the request output is low, and the status word at 0x070 reads the idle code 0x7F.
- R2: For any word-aligned address, bits [11:4] select a 16-byte slot and bits [3:2] select the operation: 00 replaces the word with the write data, 01 ORs the data in, 10 clears the bits that are 1 in the data, and 11 inverts them. A read at any of the four offsets returns the same value. The word in slot 0x000 is a plain 32-bit scratch vector word.
- R3: Line n's control word is at 0x120 + n*0x10. Bits [1:0] hold the level (0..3), bit 2 is the enable, and all other bits read 0. A disabled line never wins arbitration.
- R4: Bit 0 of the control word at 0x020 is the global request enable, and its other bits read 0. While it is 0, the request output is low and the status word reads 0x7F.
- R5: Among lines that are high and enabled, the highest level wins, and on equal levels the lowest line number wins. A status read returns the winner's number when the request output is high, and 0x7F otherwise.
- R6: A status read taken while the request is high marks the winner's level as in service. While any level at or above a candidate's level is in service, that candidate raises no request.
- R7: A pending, enabled line whose level is strictly above every in-service level raises the request even while lower levels are in service.
- R8: Writing the acknowledge word at 0x010 (through any offset) releases each level k whose data bit k is 1. A read of 0x010 returns the in-service levels as a bit mask in bits [3:0].
- R9: Interrupt inputs are level-sensitive. With one sampling stage, a change on a line reaches the request output one clock edge later, and a line that goes low leaves arbitration at that edge.
- R10: Writes to the status word have no effect on what it returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Request to the processor |

## Verification
The bench builds the block with its defaults: 128 lines, four levels, a 12-bit address and one sampling stage. At these values the control word of the last line sits at 0x910, the top of the map, so the alias operations can be checked on both the first and the last slot. One sampling stage makes the one-edge lag of R9 directly observable. With four levels, two nested claims (level 2, then level 3) and their release in reverse order can be driven through the acknowledge mask.

// File: rtl/icol_pkg.sv
package icol_pkg;

   typedef enum logic [1:0] {
      ALIAS_WR  = 2'b00,
      ALIAS_SET = 2'b01,
      ALIAS_CLR = 2'b10,
      ALIAS_TOG = 2'b11
   } alias_e;

   localparam logic [7:0] SLOT_VEC  = 8'h00;
   localparam logic [7:0] SLOT_ACK  = 8'h01;
   localparam logic [7:0] SLOT_CTRL = 8'h02;
   localparam logic [7:0] SLOT_STAT = 8'h07;
   localparam logic [7:0] SLOT_SRC0 = 8'h12;

   localparam int EN_BIT = 2;

   function automatic logic [31:0] alias_apply(input alias_e op,
                                               input logic [31:0] cur,
                                               input logic [31:0] wd);
      logic [31:0] res;
      case (op)
         ALIAS_WR:  res = wd;
         ALIAS_SET: res = cur | wd;
         ALIAS_CLR: res = cur & ~wd;
         default:   res = cur ^ wd;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/icol_src_bank.sv
module icol_src_bank
   import icol_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int LVL_W   = 2,
   parameter int SLOT_W  = 8
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_i,
   input  alias_e                   op_i,
   input  logic [SLOT_W-1:0]        idx_i,
   input  logic [31:0]              wdata_i,
   input  logic [SLOT_W-1:0]        rd_idx_i,
   output logic [31:0]              rd_word_o,
   output logic [NUM_SRC-1:0]       en_o,
   output logic [NUM_SRC*LVL_W-1:0] lvl_o
);

   if (LVL_W > EN_BIT) begin : g_bad_lvl
      $error("icol_src_bank: level field overlaps the enable bit");
   end

   logic [31:0] word [NUM_SRC];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic             en_q;
      logic [LVL_W-1:0] lvl_q;
      logic [31:0]      nxt;

      always_comb begin
         word[g]              = '0;
         word[g][EN_BIT]      = en_q;
         word[g][LVL_W-1:0]   = lvl_q;
         nxt                  = alias_apply(op_i, word[g], wdata_i);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q  <= 1'b0;
            lvl_q <= '0;
         end else if (wr_i && (idx_i == SLOT_W'(g))) begin
            en_q  <= nxt[EN_BIT];
            lvl_q <= nxt[LVL_W-1:0];
         end
      end

      assign en_o[g]                    = en_q;
      assign lvl_o[g*LVL_W +: LVL_W]    = lvl_q;
   end

   always_comb begin
      rd_word_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (rd_idx_i == SLOT_W'(i)) rd_word_o = word[i];
      end
   end

endmodule

// File: rtl/icol_arbiter.sv
module icol_arbiter #(
   parameter int NUM_SRC = 128,
   parameter int LVL_W   = 2,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NUM_SRC-1:0]       cand_i,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
   output logic                     found_o,
   output logic [IDX_W-1:0]         win_idx_o,
   output logic [LVL_W-1:0]         win_lvl_o
);

   // Scan from the top line down; ">=" lets a lower number take a tie.
   always_comb begin
      found_o   = 1'b0;
      win_idx_o = '0;
      win_lvl_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand_i[i] && (!found_o || lvl_i[i*LVL_W +: LVL_W] >= win_lvl_o)) begin
            found_o   = 1'b1;
            win_idx_o = IDX_W'(i);
            win_lvl_o = lvl_i[i*LVL_W +: LVL_W];
         end
      end
   end

   AST_WIN_IS_CANDIDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      found_o |-> cand_i[win_idx_o]); // R5

   AST_NONE_WITHOUT_CANDIDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !found_o |-> (cand_i == '0)); // R3

endmodule

// File: rtl/icol_level_gate.sv
module icol_level_gate #(
   parameter int NUM_LVL = 4,
   localparam int LVL_W  = $clog2(NUM_LVL)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               glb_en_i,
   input  logic               found_i,
   input  logic [LVL_W-1:0]   win_lvl_i,
   input  logic               claim_i,
   input  logic [NUM_LVL-1:0] ack_i,
   output logic               req_o,
   output logic [NUM_LVL-1:0] svc_o
);

   logic [NUM_LVL-1:0] svc_q;
   logic [NUM_LVL-1:0] claim_mask;

   always_comb begin
      claim_mask = '0;
      if (claim_i) claim_mask[win_lvl_i] = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) svc_q <= '0;
      else         svc_q <= (svc_q & ~ack_i) | claim_mask;
   end

   // Any in-service level at or above the candidate's level blocks it.
   assign req_o = glb_en_i & found_i & ~|(svc_q >> win_lvl_i);
   assign svc_o = svc_q;

   AST_CLAIM_MARKS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_i |=> svc_q[$past(win_lvl_i)]); // R6

   AST_ACK_RELEASES_L0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[0] && !(claim_i && win_lvl_i == '0)) |=> !svc_q[0]); // R8

   AST_REQ_ONLY_WITH_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |-> found_i); // R5

endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import icol_pkg::*;
#(
   parameter int          NUM_SRC     = 128,
   parameter int          NUM_LVL     = 4,
   parameter int          ADDR_W      = 12,
   parameter int          SYNC_STAGES = 1,
   parameter logic [31:0] IDLE_CODE   = 32'h7F
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_rd_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   output logic               irq_o
);

   localparam int LVL_W  = $clog2(NUM_LVL);
   localparam int SLOT_W = ADDR_W - 4;
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int MAP_END = 16 * (int'(SLOT_SRC0) + NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > 128) begin : g_bad_src
      $error("irq_collector: NUM_SRC must be within 2..128");
   end
   if (NUM_LVL != 2 && NUM_LVL != 4) begin : g_bad_lvl
      $error("irq_collector: NUM_LVL must be 2 or 4");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_collector: ADDR_W too small for the line slots");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_sync
      $error("irq_collector: SYNC_STAGES must be 1 or 2");
   end

   // ---------------- input sampling ----------------
   logic [NUM_SRC-1:0] src_q;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) src_q <= '0;
         else         src_q <= src_i;
      end
   end else begin : g_sync2
      logic [NUM_SRC-1:0] meta_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            meta_q <= '0;
            src_q  <= '0;
         end else begin
            meta_q <= src_i;
            src_q  <= meta_q;
         end
      end
   end

   // ---------------- address decode ----------------
   logic [SLOT_W-1:0] slot;
   alias_e            op;
   logic              aligned;
   logic              in_src;
   logic [SLOT_W-1:0] src_idx;

   assign slot    = bus_addr_i[ADDR_W-1:4];
   assign op      = alias_e'(bus_addr_i[3:2]);
   assign aligned = (bus_addr_i[1:0] == 2'b00);
   assign src_idx = slot - SLOT_W'(SLOT_SRC0);
   assign in_src  = (slot >= SLOT_W'(SLOT_SRC0)) &&
                    (slot <  SLOT_W'(int'(SLOT_SRC0) + NUM_SRC));

   logic wr_ok, rd_ok;
   assign wr_ok = bus_wr_i && aligned;
   assign rd_ok = bus_rd_i && aligned;

   // ---------------- plain words ----------------
   logic [31:0] vec_q;
   logic        glb_en_q;
   logic [31:0] ctrl_word;
   logic [31:0] ctrl_nxt;

   assign ctrl_word = {31'b0, glb_en_q};
   assign ctrl_nxt  = alias_apply(op, ctrl_word, bus_wdata_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vec_q    <= '0;
         glb_en_q <= 1'b0;
      end else begin
         if (wr_ok && slot == SLOT_W'(SLOT_VEC))
            vec_q <= alias_apply(op, vec_q, bus_wdata_i);
         if (wr_ok && slot == SLOT_W'(SLOT_CTRL))
            glb_en_q <= ctrl_nxt[0];
      end
   end

   // ---------------- per-line controls ----------------
   logic [NUM_SRC-1:0]       en;
   logic [NUM_SRC*LVL_W-1:0] lvl;
   logic [31:0]              src_word;

   icol_src_bank #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W),
      .SLOT_W  (SLOT_W)
   ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_ok && in_src),
      .op_i      (op),
      .idx_i     (src_idx),
      .wdata_i   (bus_wdata_i),
      .rd_idx_i  (src_idx),
      .rd_word_o (src_word),
      .en_o      (en),
      .lvl_o     (lvl)
   );

   // ---------------- arbitration and level gating ----------------
   logic             found;
   logic [IDX_W-1:0] win_idx;
   logic [LVL_W-1:0] win_lvl;

   icol_arbiter #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W)
   ) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cand_i    (src_q & en),
      .lvl_i     (lvl),
      .found_o   (found),
      .win_idx_o (win_idx),
      .win_lvl_o (win_lvl)
   );

   logic               claim;
   logic [NUM_LVL-1:0] ack;
   logic [NUM_LVL-1:0] svc;

   assign claim = rd_ok && (slot == SLOT_W'(SLOT_STAT)) && irq_o;
   assign ack   = (wr_ok && slot == SLOT_W'(SLOT_ACK)) ? bus_wdata_i[NUM_LVL-1:0] : '0;

   icol_level_gate #(
      .NUM_LVL (NUM_LVL)
   ) u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .glb_en_i  (glb_en_q),
      .found_i   (found),
      .win_lvl_i (win_lvl),
      .claim_i   (claim),
      .ack_i     (ack),
      .req_o     (irq_o),
      .svc_o     (svc)
   );

   // ---------------- read path ----------------
   logic [31:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (in_src) begin
         rd_mux = src_word;
      end else begin
         case (slot)
            SLOT_W'(SLOT_VEC):  rd_mux = vec_q;
            SLOT_W'(SLOT_ACK):  rd_mux = 32'(svc);
            SLOT_W'(SLOT_CTRL): rd_mux = ctrl_word;
            SLOT_W'(SLOT_STAT): rd_mux = irq_o ? 32'(win_idx) : IDLE_CODE;
            default:            rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    bus_rdata_o <= '0;
      else if (rd_ok) bus_rdata_o <= rd_mux;
   end

   AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !glb_en_q |-> !irq_o); // R4

   AST_STATUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok && slot == SLOT_W'(SLOT_STAT) && !irq_o) |=> (bus_rdata_o == IDLE_CODE)); // R5

   AST_DISABLED_NEVER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> en[win_idx]); // R3

endmodule

// File: tb/tb_irq_collector.sv
module tb_irq_collector;

   localparam int NSRC = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src = '0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_collector dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .src_i       (src),
      .bus_rd_i    (bus_rd),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // {is_read, address, data (write data or expected read value)}
   localparam int NVEC = 19;
   localparam logic [44:0] VEC [NVEC] = '{
      {1'b0, 12'h000, 32'hA5A5_0F0F},
      {1'b1, 12'h000, 32'hA5A5_0F0F},
      {1'b0, 12'h004, 32'h0000_00F0},
      {1'b1, 12'h008, 32'hA5A5_0FFF},
      {1'b0, 12'h008, 32'hA000_0000},
      {1'b1, 12'h00C, 32'h05A5_0FFF},
      {1'b0, 12'h00C, 32'hFFFF_0000},
      {1'b1, 12'h004, 32'hFA5A_0FFF},
      {1'b0, 12'h910, 32'hFFFF_FFFF},
      {1'b1, 12'h910, 32'h0000_0007},
      {1'b0, 12'h918, 32'h0000_0004},
      {1'b1, 12'h91C, 32'h0000_0003},
      {1'b0, 12'h91C, 32'h0000_0001},
      {1'b1, 12'h910, 32'h0000_0002},
      {1'b0, 12'h910, 32'h0000_0000},
      {1'b0, 12'h020, 32'hFFFF_FFFF},
      {1'b1, 12'h02C, 32'h0000_0001},
      {1'b0, 12'h028, 32'h0000_0001},
      {1'b1, 12'h020, 32'h0000_0000}
   };

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();

      // R1 reset state
      check("R1 irq", 32'(irq), 32'h0);
      rd(12'h070, d); check("R1 status", d, 32'h7F);
      rd(12'h170, d); check("R1 line5 word", d, 32'h0);
      rd(12'h020, d); check("R1 ctrl", d, 32'h0);
      rd(12'h010, d); check("R1 in-service", d, 32'h0);

      // R2 / R3 / R4 alias table
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][44]) begin
            rd(VEC[i][43:32], d);
            if (VEC[i][43:32] >= 12'h120) check("R3 table read", d, VEC[i][31:0]);
            else                          check("R2 table read", d, VEC[i][31:0]);
         end else begin
            wr(VEC[i][43:32], VEC[i][31:0]);
         end
      end

      // R3 line 3: enable via set alias, level 1 via toggle alias
      wr(12'h154, 32'h4);
      wr(12'h15C, 32'h1);
      rd(12'h150, d); check("R3 line3 word", d, 32'h5);

      // R4 global enable gates the request
      src[3] = 1'b1; tick();
      check("R4 irq while off", 32'(irq), 32'h0);
      rd(12'h070, d); check("R4 status while off", d, 32'h7F);
      wr(12'h024, 32'h1);
      check("R4 irq when on", 32'(irq), 32'h1);
      wr(12'h028, 32'h1);
      check("R4 irq after clear", 32'(irq), 32'h0);
      wr(12'h024, 32'h1);

      // R5 arbitration: lines 10 (lvl1), 20 (lvl2), 30 (lvl2)
      wr(12'h1C0, 32'h5);
      wr(12'h260, 32'h6);
      wr(12'h300, 32'h6);
      src[10] = 1'b1; src[20] = 1'b1; src[30] = 1'b1; tick();
      rd(12'h070, d); check("R5 winner level2 tie", d, 32'd20);
      check("R6 gated after claim", 32'(irq), 32'h0);
      rd(12'h010, d); check("R8 mask after claim", d, 32'h4);

      // R7 higher level preempts
      wr(12'h3A0, 32'h7);
      src[40] = 1'b1; tick();
      check("R7 irq for level3", 32'(irq), 32'h1);
      rd(12'h070, d); check("R7 status level3", d, 32'd40);
      rd(12'h010, d); check("R8 nested mask", d, 32'hC);

      src[40] = 1'b0; tick();
      wr(12'h010, 32'h8);
      check("R6 level2 still held", 32'(irq), 32'h0);
      rd(12'h010, d); check("R8 after level3 ack", d, 32'h4);
      wr(12'h014, 32'h4);
      check("R8 request after ack", 32'(irq), 32'h1);

      // R3 masking and R5 tie on level 1 (lines 3 and 10)
      wr(12'h268, 32'h4);
      wr(12'h308, 32'h4);
      rd(12'h070, d); check("R5 tie lowest number", d, 32'd3);
      check("R6 level1 gated", 32'(irq), 32'h0);
      wr(12'h010, 32'h2);
      check("R8 released level1", 32'(irq), 32'h1);

      // R9 one-edge lag on input drop
      src = '0;
      #1;
      check("R9 irq before edge", 32'(irq), 32'h1);
      @(negedge clk);
      check("R9 irq after edge", 32'(irq), 32'h0);
      rd(12'h070, d); check("R5 idle status", d, 32'h7F);

      // R10 writes to status ignored
      wr(12'h070, 32'h5);
      rd(12'h070, d); check("R10 idle after write", d, 32'h7F);
      src[3] = 1'b1; tick();
      wr(12'h074, 32'h0);
      rd(12'h070, d); check("R10 winner after write", d, 32'd3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule